// File: doc/BRIEF.md
# Excess-One Square-Root Carry-Select Adder

This block adds two 16-bit unsigned operands and a carry-in in one combinational pass, giving a 16-bit sum and a carry-out. The operand width is split into five groups whose widths grow toward the most significant end (2, 2, 3, 4 and 5 bits). Growing the groups this way lets each group finish its local work at about the time the carry from below reaches it.

The lowest group is a plain ripple adder that takes the external carry-in. Every group above it prepares two candidate results: one that assumes a carry of zero and one that assumes a carry of one. The real carry from the group below then picks one with a 2:1 multiplexer. The second group builds both candidates with two small ripple adders. Groups three to five use a single zero-carry ripple adder. An incrementer one bit wider than that adder then adds one to the ripple adder's carry and sum, and the result is the carry-of-one candidate. This avoids a second ripple adder in those groups. The carry bit chosen by each multiplexer drives the select of the next group. The carry bit chosen in the top group is the carry-out.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every input, {carry_out, sum_o} equals op_a + op_b + carry_in, computed as an unsigned 17-bit value.
- R2: sum_o[1:0] depends only on op_a[1:0], op_b[1:0] and carry_in, and equals the low two bits of their sum.
- R3: The incrementer wraps: when the zero-carry result of a group is all ones and that group's carry input is 1, the group's sum bits become all zeros and it passes a carry of 1 upward. At the ports, 0xFFFF + 0x0000 + 1 gives sum 0x0000 with carry_out 1.
- R4: A carry that leaves any group enters the next group correctly at each group boundary (bit positions 2, 4, 7 and 11). An operand with ones below the boundary, plus 1, gives a single one at the boundary bit.
- R5: carry_out is 1 exactly when the true 17-bit total is 0x10000 or more, including the totals 0x1FFFF and 0x1FFFE.
- R6: The block holds no state. The same inputs give the same outputs whatever inputs came before.
- R7: With both operands zero, sum_o equals carry_in in bit 0 and is zero elsewhere, and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First unsigned operand |
| op_b | input | 16 | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Bit 16 of the total |

## Verification
The case hardest to reach from the ports is the wraparound of an upper group's incrementer. It needs that group's zero-carry ripple result to be all ones while the group below produces a carry. Random operands seldom line this up in every group at once. The stimulus therefore includes all-ones operands with a carry-in, and operands that are all ones below each group boundary plus one. It also sweeps the low nibbles of both operands and the carry-in exhaustively, once with the upper bits all zero and once with them all ones. With the upper bits all ones, any carry out of the low bits has to ripple through every incrementer.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;

    localparam int NUM_GRP = 5;

    // width of group g, counted from the least significant end
    function automatic int grp_width(input int g);
        case (g)
            0:       return 2;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // first bit position of group g
    function automatic int grp_base(input int g);
        int acc;
        acc = 0;
        for (int k = 0; k < g; k++) acc += grp_width(k);
        return acc;
    endfunction

    function automatic int total_width();
        return grp_base(NUM_GRP);
    endfunction

endpackage

// File: rtl/csa_ripple.sv
`timescale 1ns/1ps
module csa_ripple #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    logic chain_d;

    always_comb begin
        chain_d = c_i;
        for (int i = 0; i < W; i++) begin
            s_o[i]  = a_i[i] ^ b_i[i] ^ chain_d;
            chain_d = (a_i[i] & b_i[i]) | (chain_d & (a_i[i] ^ b_i[i]));
        end
        c_o = chain_d;
    end

endmodule

// File: rtl/csa_excess1.sv
`timescale 1ns/1ps
module csa_excess1 #(
    parameter int W = 3
) (
    input  logic [W-1:0] b_i,
    output logic [W-1:0] x_o
);

    // bit i flips when every lower bit is one; bit 0 always flips
    logic all_low_d;

    always_comb begin
        all_low_d = 1'b1;
        for (int i = 0; i < W; i++) begin
            x_o[i]    = b_i[i] ^ all_low_d;
            all_low_d = all_low_d & b_i[i];
        end
    end

endmodule

// File: rtl/csa_group.sv
`timescale 1ns/1ps
module csa_group #(
    parameter int W           = 3,
    parameter bit DUAL_RIPPLE = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    localparam int RW = W + 1;

    logic [W-1:0]  s_zero;
    logic          c_zero;
    logic [RW-1:0] word_zero;
    logic [RW-1:0] word_one;

    csa_ripple #(.W(W)) u_rip_zero (
        .a_i (a_i),
        .b_i (b_i),
        .c_i (1'b0),
        .s_o (s_zero),
        .c_o (c_zero)
    );

    assign word_zero = {c_zero, s_zero};

    generate
        if (DUAL_RIPPLE) begin : g_dual
            logic [W-1:0] s_one;
            logic         c_one;
            csa_ripple #(.W(W)) u_rip_one (
                .a_i (a_i),
                .b_i (b_i),
                .c_i (1'b1),
                .s_o (s_one),
                .c_o (c_one)
            );
            assign word_one = {c_one, s_one};
        end else begin : g_inc
            csa_excess1 #(.W(RW)) u_inc (
                .b_i (word_zero),
                .x_o (word_one)
            );
        end
    endgenerate

    always_comb begin
        if (sel_i) {c_o, s_o} = word_one;
        else       {c_o, s_o} = word_zero;
    end

endmodule

// File: rtl/csa_sqrt_adder.sv
`timescale 1ns/1ps
module csa_sqrt_adder (
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic        carry_in,
    output logic [15:0] sum_o,
    output logic        carry_out
);

    localparam int NG     = csa_pkg::NUM_GRP;
    localparam int DATA_W = csa_pkg::total_width();

    logic [NG:0]       grp_c;
    logic [DATA_W-1:0] sum_d;

    assign grp_c[0] = carry_in;

    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            localparam int GW = csa_pkg::grp_width(g);
            localparam int GB = csa_pkg::grp_base(g);
            if (g == 0) begin : g_base
                csa_ripple #(.W(GW)) u_rip (
                    .a_i (op_a[GB +: GW]),
                    .b_i (op_b[GB +: GW]),
                    .c_i (grp_c[g]),
                    .s_o (sum_d[GB +: GW]),
                    .c_o (grp_c[g+1])
                );
            end else begin : g_sel
                csa_group #(.W(GW), .DUAL_RIPPLE(g == 1)) u_grp (
                    .a_i   (op_a[GB +: GW]),
                    .b_i   (op_b[GB +: GW]),
                    .sel_i (grp_c[g]),
                    .s_o   (sum_d[GB +: GW]),
                    .c_o   (grp_c[g+1])
                );
            end
        end
    endgenerate

    assign sum_o     = sum_d;
    assign carry_out = grp_c[NG];

endmodule

// File: rtl/csa_sqrt_adder_chk.sv
`timescale 1ns/1ps
module csa_sqrt_adder_chk (
    input logic [15:0] op_a,
    input logic [15:0] op_b,
    input logic        carry_in,
    input logic [15:0] sum_o,
    input logic        carry_out
);

    logic [16:0] ref_total;
    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in};

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sum_o, carry_out})) begin
            AST_SUM_EXACT: assert ({carry_out, sum_o} == ref_total); // R1
            AST_LOW_GROUP: assert (sum_o[1:0] == 2'(op_a[1:0] + op_b[1:0] + {1'b0, carry_in})); // R2
            if (op_a == 16'hFFFF && op_b == 16'h0000 && carry_in) begin
                AST_ALLONES_WRAP: assert (sum_o == 16'h0000 && carry_out); // R3
            end
            AST_CARRY_OUT: assert (carry_out == ({1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in} > 17'h0FFFF)); // R5
            if (op_a == 16'd0 && op_b == 16'd0) begin
                AST_ZERO_OPERANDS: assert (sum_o == {15'd0, carry_in} && !carry_out); // R7
            end
        end
    end

endmodule

module csa_excess1_chk #(
    parameter int W = 3
) (
    input logic [W-1:0] b_i,
    input logic [W-1:0] x_o
);

    always_comb begin
        if (!$isunknown({b_i, x_o})) begin
            AST_INC_WRAP: assert (x_o == W'(b_i + 1'b1)); // R3
        end
    end

endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_o     (sum_o),
    .carry_out (carry_out)
);

bind csa_excess1 csa_excess1_chk #(.W(W)) u_inc_chk (
    .b_i (b_i),
    .x_o (x_o)
);

// File: tb/test_csa_sqrt_adder.sv
`timescale 1ns/1ps
module test_csa_sqrt_adder;

    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_o;
    logic        carry_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    csa_sqrt_adder i_csa_sqrt_adder (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_o     (sum_o),
        .carry_out (carry_out)
    );

    // {a, b, cin, expected 17-bit total}
    localparam int NV = 13;
    localparam logic [49:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000},
        {16'h0000, 16'h0000, 1'b1, 17'h00001},
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        {16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},
        {16'h0003, 16'h0001, 1'b0, 17'h00004},
        {16'h000F, 16'h0001, 1'b0, 17'h00010},
        {16'h007F, 16'h0001, 1'b0, 17'h00080},
        {16'h07FF, 16'h0000, 1'b1, 17'h00800},
        {16'h1234, 16'h4321, 1'b0, 17'h05555},
        {16'h8000, 16'h8000, 1'b0, 17'h10000},
        {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
        {16'h0003, 16'h0000, 1'b1, 17'h00004}
    };
    localparam string VTAG [NV] = '{"R7", "R7", "R3", "R5", "R5", "R4", "R4",
                                    "R4", "R4", "R1", "R5", "R1", "R2"};

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(posedge clk);
        op_a     = a;
        op_b     = b;
        carry_in = c;
        @(negedge clk);
    endtask

    task automatic check17(input string tag, input logic [16:0] exp_v);
        checks++;
        if ({carry_out, sum_o} !== exp_v) begin
            failures++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     tag, op_a, op_b, carry_in, {carry_out, sum_o}, exp_v);
        end
    endtask

    task automatic check2(input string tag, input logic [1:0] exp_v);
        checks++;
        if (sum_o[1:0] !== exp_v) begin
            failures++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     tag, op_a, op_b, carry_in, sum_o[1:0], exp_v);
        end
    endtask

    initial begin
        logic [31:0] rng;
        logic [16:0] exp_t;

        // reset-like idle state: zero inputs give zero outputs (R7)
        @(negedge clk);
        check17("R7", 17'h00000);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
            check17(VTAG[i], VEC[i][16:0]);
        end

        // exhaustive low nibbles, upper bits clear or set (R1, R2, R3)
        for (int u = 0; u < 2; u++) begin
            for (int n = 0; n < 512; n++) begin
                logic [15:0] a;
                logic [15:0] b;
                logic        c;
                a = {(u == 1) ? 12'hFFF : 12'h000, 4'(n >> 5)};
                b = {12'h000, 4'(n >> 1)};
                c = n[0];
                apply(a, b, c);
                exp_t = {1'b0, a} + {1'b0, b} + {16'd0, c};
                check17("R1", exp_t);
                check2("R2", exp_t[1:0]);
            end
        end

        // carry into each group boundary from both operands (R4)
        for (int k = 0; k < 4; k++) begin
            int pos;
            pos = (k == 0) ? 2 : (k == 1) ? 4 : (k == 2) ? 7 : 11;
            apply(16'((1 << pos) - 1), 16'h0000, 1'b1);
            check17("R4", 17'(1 << pos));
            apply(16'h0001, 16'((1 << pos) - 1), 1'b0);
            check17("R4", 17'(1 << pos));
        end

        // no state: same vector after different histories (R6)
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        apply(16'h00FF, 16'hFF01, 1'b0);
        check17("R6", 17'h10000);
        apply(16'h0000, 16'h0000, 1'b0);
        apply(16'h00FF, 16'hFF01, 1'b0);
        check17("R6", 17'h10000);

        // pseudo-random vectors (R1, R5)
        rng = 32'h1ACE_B00C;
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] a;
            logic [15:0] b;
            rng ^= rng << 13;
            rng ^= rng >> 17;
            rng ^= rng << 5;
            a = rng[31:16];
            b = rng[15:0] ^ rng[23:8];
            apply(a, b, rng[3]);
            exp_t = {1'b0, a} + {1'b0, b} + {16'd0, rng[3]};
            check17((n % 2 == 0) ? "R1" : "R5", exp_t);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule